// File: doc/BRIEF.md
# Branch and Effective Address Unit

This unit works out where a 16-bit processor goes next and which memory word an instruction touches. Each cycle it takes the program counter as it stands after fetch (already advanced by one), the instruction word, the value of the selected base register, the current condition flags and, for the second phase of an indirect access, the pointer word just read from memory. One clock later it presents the next program counter, a word address, a qualifier saying whether that address is a real memory access, and a branch-taken flag.

Offsets come in two sizes. Branches, PC-relative loads and stores, indirect accesses and address-load instructions use a 9-bit signed field. Base-plus-offset accesses use a 6-bit signed field added to the base register. Indirect loads and stores are run in two phases by the sequencer. The phase input set low gives the PC-relative pointer location. The phase input set high passes the fetched pointer through as the final address. Every sum wraps modulo 2^16. The unit neither reads nor writes memory or registers.

Top module: `eaUnit`

## Requirements
- R1: While `rstN` is low, every output is zero at the following clock edge. Outside reset, the outputs registered at a clock edge are computed from the inputs sampled at that same edge, so there is one cycle of latency.
- R2: The opcode is `instr[15:12]`. A branch uses opcode 0000. Its mask is `instr[11:9]`, with bit 11 for N, bit 10 for Z and bit 9 for C. `condFlags` is {N,Z,C}, with N at bit 2. The branch is taken when some mask bit and the matching flag are both set. A mask of 000 is never taken.
- R3: A taken branch sets `nextPc` to `incPc` plus the sign-extended `instr[8:0]`.
- R4: If the instruction is not a branch, or the branch is not taken, `nextPc` equals `incPc` and `branchTaken` is 0.
- R5: Load (0010) and store (0011) give `memAddr` = `incPc` + sign-extended `instr[8:0]`, with `memAccess` = 1.
- R6: Base load (0110) and base store (0111) give `memAddr` = `baseVal` + sign-extended `instr[5:0]`, with `memAccess` = 1.
- R7: Address load (1110) gives `memAddr` = `incPc` + sign-extended `instr[8:0]`, with `memAccess` = 0.
- R8: Indirect load (1010) and indirect store (1011) give `memAddr` = `incPc` + sign-extended `instr[8:0]` when `indStep` is 0, and `memAddr` = `ptrWord` when `indStep` is 1. In both cases `memAccess` = 1.
- R9: Every other opcode gives `memAddr` = 0, `memAccess` = 0 and `branchTaken` = 0. `indStep` has no effect on any opcode other than 1010 and 1011.
- R10: All address and PC sums wrap modulo 2^16, whether the offset is positive or negative.
- R11: A branch mask of 111 is always taken, even when `condFlags` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| incPc | input | 16 | Program counter after the fetch increment |
| instr | input | 16 | Instruction word |
| baseVal | input | 16 | Value of the base register selected by instr[8:6] |
| condFlags | input | 3 | Condition flags {N,Z,C} |
| ptrWord | input | 16 | Pointer word read in the first indirect phase |
| indStep | input | 1 | High during the second indirect phase |
| nextPc | output | 16 | Next program counter |
| memAddr | output | 16 | Word address |
| memAccess | output | 1 | memAddr is a memory access |
| branchTaken | output | 1 | Branch condition met |

## Verification
The hardest cases are the ones where an input must have no effect. Examples are the indirect phase bit asserted on a plain load or on an unrelated opcode, and flags that are set but not selected by the mask. The stimulus drives `indStep` high with ordinary PC-relative and non-memory opcodes and checks that the address is still the PC-relative sum or zero. It also drives each branch mask against flag patterns that miss it and against patterns that hit it. Wrap-around needs operands near both ends of the address space, so the bench places `incPc` and `baseVal` just below 0x0000 with positive offsets and just above it with negative offsets.

// File: rtl/eaUnitPkg.sv
package eaUnitPkg;

  localparam logic [3:0] OP_BR  = 4'b0000;
  localparam logic [3:0] OP_LD  = 4'b0010;
  localparam logic [3:0] OP_ST  = 4'b0011;
  localparam logic [3:0] OP_LDR = 4'b0110;
  localparam logic [3:0] OP_STR = 4'b0111;
  localparam logic [3:0] OP_LDI = 4'b1010;
  localparam logic [3:0] OP_STI = 4'b1011;
  localparam logic [3:0] OP_LEA = 4'b1110;

  typedef struct packed {
    logic isBranch;
    logic usePcRel;
    logic useBase;
    logic usePtr;
    logic memAccess;
  } eaStrobes_t;

endpackage

// File: rtl/eaControl.sv
module eaControl
  import eaUnitPkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             indStep,
  output eaStrobes_t       strobes
);

  always_comb begin
    strobes = '0;
    case (opcode)
      OP_BR: strobes.isBranch = 1'b1;
      OP_LD, OP_ST: begin
        strobes.usePcRel  = 1'b1;
        strobes.memAccess = 1'b1;
      end
      OP_LDR, OP_STR: begin
        strobes.useBase   = 1'b1;
        strobes.memAccess = 1'b1;
      end
      OP_LDI, OP_STI: begin
        // first phase points at the pointer, second uses the fetched word
        strobes.usePcRel  = !indStep;
        strobes.usePtr    = indStep;
        strobes.memAccess = 1'b1;
      end
      OP_LEA: strobes.usePcRel = 1'b1;
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/eaDatapath.sv
module eaDatapath
  import eaUnitPkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FIELD_W     = 12,
  parameter int LONG_OFF_W  = 9,
  parameter int SHORT_OFF_W = 6,
  parameter int FLAG_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  eaStrobes_t         strobes,
  input  logic [WORD_W-1:0]  incPc,
  input  logic [FIELD_W-1:0] field,
  input  logic [WORD_W-1:0]  baseVal,
  input  logic [FLAG_W-1:0]  condFlags,
  input  logic [WORD_W-1:0]  ptrWord,
  output logic [WORD_W-1:0]  nextPc,
  output logic [WORD_W-1:0]  memAddr,
  output logic               memAccess,
  output logic               branchTaken
);

  localparam int LONG_PAD  = WORD_W - LONG_OFF_W;
  localparam int SHORT_PAD = WORD_W - SHORT_OFF_W;
  localparam int MASK_LO   = LONG_OFF_W;
  localparam int MASK_HI   = LONG_OFF_W + FLAG_W - 1;

  logic [WORD_W-1:0] longExt;
  logic [WORD_W-1:0] shortExt;
  logic [WORD_W-1:0] pcRelSum;
  logic [WORD_W-1:0] baseSum;
  logic [FLAG_W-1:0] condMask;
  logic [FLAG_W-1:0] flagHit;
  logic              maskAll;
  logic              takenD;
  logic [WORD_W-1:0] nextPcD;
  logic [WORD_W-1:0] addrD;

  assign longExt  = {{LONG_PAD{field[LONG_OFF_W-1]}}, field[LONG_OFF_W-1:0]};
  assign shortExt = {{SHORT_PAD{field[SHORT_OFF_W-1]}}, field[SHORT_OFF_W-1:0]};

  // two independent adders: PC-relative and base-relative
  assign pcRelSum = incPc + longExt;
  assign baseSum  = baseVal + shortExt;

  assign condMask = field[MASK_HI:MASK_LO];

  genvar g;
  generate
    for (g = 0; g < FLAG_W; g++) begin : gFlag
      assign flagHit[g] = condMask[g] & condFlags[g];
    end
  endgenerate

  assign maskAll = &condMask;
  assign takenD  = strobes.isBranch & (maskAll | (|flagHit));
  assign nextPcD = takenD ? pcRelSum : incPc;

  always_comb begin
    addrD = '0;
    if (strobes.usePtr)
      addrD = ptrWord;
    else if (strobes.useBase)
      addrD = baseSum;
    else if (strobes.usePcRel)
      addrD = pcRelSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc      <= '0;
      memAddr     <= '0;
      memAccess   <= 1'b0;
      branchTaken <= 1'b0;
    end else begin
      nextPc      <= nextPcD;
      memAddr     <= addrD;
      memAccess   <= strobes.memAccess;
      branchTaken <= takenD;
    end
  end

endmodule

// File: rtl/eaUnit.sv
module eaUnit
  import eaUnitPkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int LONG_OFF_W  = 9,
  parameter int SHORT_OFF_W = 6,
  parameter int FLAG_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] incPc,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] baseVal,
  input  logic [FLAG_W-1:0] condFlags,
  input  logic [WORD_W-1:0] ptrWord,
  input  logic              indStep,
  output logic [WORD_W-1:0] nextPc,
  output logic [WORD_W-1:0] memAddr,
  output logic              memAccess,
  output logic              branchTaken
);

  localparam int OPC_W   = 4;
  localparam int FIELD_W = WORD_W - OPC_W;

  eaStrobes_t strobes;

  eaControl #(.OPC_W(OPC_W)) i_control (
    .opcode  (instr[WORD_W-1 -: OPC_W]),
    .indStep (indStep),
    .strobes (strobes)
  );

  eaDatapath #(
    .WORD_W      (WORD_W),
    .FIELD_W     (FIELD_W),
    .LONG_OFF_W  (LONG_OFF_W),
    .SHORT_OFF_W (SHORT_OFF_W),
    .FLAG_W      (FLAG_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .incPc       (incPc),
    .field       (instr[FIELD_W-1:0]),
    .baseVal     (baseVal),
    .condFlags   (condFlags),
    .ptrWord     (ptrWord),
    .nextPc      (nextPc),
    .memAddr     (memAddr),
    .memAccess   (memAccess),
    .branchTaken (branchTaken)
  );

endmodule

// File: rtl/eaUnitChecker.sv
module eaUnitChecker #(
  parameter int WORD_W      = 16,
  parameter int LONG_OFF_W  = 9,
  parameter int SHORT_OFF_W = 6,
  parameter int FLAG_W      = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] incPc,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] baseVal,
  input logic [FLAG_W-1:0] condFlags,
  input logic [WORD_W-1:0] ptrWord,
  input logic              indStep,
  input logic [WORD_W-1:0] nextPc,
  input logic [WORD_W-1:0] memAddr,
  input logic              memAccess,
  input logic              branchTaken
);

  logic [3:0]        op;
  logic [2:0]        mask;
  logic [WORD_W-1:0] longOff;
  logic [WORD_W-1:0] shortOff;
  logic              otherOp;
  logic              flagMatch;
  logic              primed  = 1'b0;
  logic              wasRst  = 1'b0;

  assign op        = instr[WORD_W-1 -: 4];
  assign mask      = instr[LONG_OFF_W+2:LONG_OFF_W];
  assign longOff   = {{(WORD_W-LONG_OFF_W){instr[LONG_OFF_W-1]}}, instr[LONG_OFF_W-1:0]};
  assign shortOff  = {{(WORD_W-SHORT_OFF_W){instr[SHORT_OFF_W-1]}}, instr[SHORT_OFF_W-1:0]};
  assign flagMatch = |(mask & condFlags[2:0]);

  always_comb begin
    case (op)
      4'b0000, 4'b0010, 4'b0011, 4'b0110, 4'b0111,
      4'b1010, 4'b1011, 4'b1110: otherOp = 1'b0;
      default:                   otherOp = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    primed <= rstN;
    wasRst <= !rstN;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    wasRst |-> (nextPc == '0 && memAddr == '0 && !memAccess && !branchTaken));

  assert_taken_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(op) == 4'b0000 && $past(mask) != 3'b111 |->
      branchTaken == $past(flagMatch));

  assert_taken_target_R3: assert property (@(posedge clk) disable iff (!rstN)
    primed && branchTaken |-> nextPc == $past(incPc) + $past(longOff));

  assert_fallthrough_R4: assert property (@(posedge clk) disable iff (!rstN)
    primed && !branchTaken |-> nextPc == $past(incPc));

  assert_pcrel_R5: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(op[3:1]) == 3'b001 |->
      memAccess && memAddr == $past(incPc) + $past(longOff));

  assert_base_R6: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(op[3:1]) == 3'b011 |->
      memAccess && memAddr == $past(baseVal) + $past(shortOff));

  assert_lea_R7: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(op) == 4'b1110 |->
      !memAccess && memAddr == $past(incPc) + $past(longOff));

  assert_ptr_R8: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(op[3:1]) == 3'b101 && $past(indStep) |->
      memAccess && memAddr == $past(ptrWord));

  assert_other_R9: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(otherOp) |-> !memAccess && memAddr == '0 && !branchTaken);

  assert_uncond_R11: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(op) == 4'b0000 && $past(mask) == 3'b111 |-> branchTaken);

endmodule

bind eaUnit eaUnitChecker #(
  .WORD_W      (WORD_W),
  .LONG_OFF_W  (LONG_OFF_W),
  .SHORT_OFF_W (SHORT_OFF_W),
  .FLAG_W      (FLAG_W)
) i_eaUnitChecker (
  .clk         (clk),
  .rstN        (rstN),
  .incPc       (incPc),
  .instr       (instr),
  .baseVal     (baseVal),
  .condFlags   (condFlags),
  .ptrWord     (ptrWord),
  .indStep     (indStep),
  .nextPc      (nextPc),
  .memAddr     (memAddr),
  .memAccess   (memAccess),
  .branchTaken (branchTaken)
);

// File: tb/test_eaUnit.sv
module test_eaUnit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] incPc = '0;
  logic [15:0] instr = '0;
  logic [15:0] baseVal = '0;
  logic [2:0]  condFlags = '0;
  logic [15:0] ptrWord = '0;
  logic        indStep = 1'b0;
  logic [15:0] nextPc;
  logic [15:0] memAddr;
  logic        memAccess;
  logic        branchTaken;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [15:0] nextPc;
    logic [15:0] memAddr;
    logic        memAccess;
    logic        taken;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eaUnit i_eaUnit (
    .clk(clk), .rstN(rstN), .incPc(incPc), .instr(instr), .baseVal(baseVal),
    .condFlags(condFlags), .ptrWord(ptrWord), .indStep(indStep),
    .nextPc(nextPc), .memAddr(memAddr), .memAccess(memAccess),
    .branchTaken(branchTaken)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one instruction and queues the expected outcome
  task automatic drive(input logic [15:0] pc, input logic [15:0] ins,
                       input logic [15:0] base, input logic [2:0] flags,
                       input logic [15:0] ptr, input logic ind, input string tag);
    expItem_t e;
    logic [3:0]  op;
    logic [15:0] s9;
    logic [15:0] s6;
    @(negedge clk);
    incPc = pc; instr = ins; baseVal = base; condFlags = flags;
    ptrWord = ptr; indStep = ind;
    op = ins[15:12];
    s9 = {{7{ins[8]}}, ins[8:0]};
    s6 = {{10{ins[5]}}, ins[5:0]};
    e.tag = tag;
    e.taken = (op == 4'b0000) && ((ins[11:9] == 3'b111) || ((ins[11:9] & flags) != 3'b000));
    e.nextPc = e.taken ? pc + s9 : pc;
    case (op)
      4'b0010, 4'b0011: begin e.memAddr = pc + s9;   e.memAccess = 1'b1; end
      4'b0110, 4'b0111: begin e.memAddr = base + s6; e.memAccess = 1'b1; end
      4'b1110:          begin e.memAddr = pc + s9;   e.memAccess = 1'b0; end
      4'b1010, 4'b1011: begin e.memAddr = ind ? ptr : pc + s9; e.memAccess = 1'b1; end
      default:          begin e.memAddr = '0;        e.memAccess = 1'b0; end
    endcase
    expQ.push_back(e);
  endtask

  // monitor: outputs registered at this edge belong to the oldest item
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(e.tag, "nextPc", nextPc, e.nextPc);
      check(e.tag, "memAddr", memAddr, e.memAddr);
      check(e.tag, "memAccess", {15'd0, memAccess}, {15'd0, e.memAccess});
      check(e.tag, "branchTaken", {15'd0, branchTaken}, {15'd0, e.taken});
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset clears outputs even with live inputs
    incPc = 16'h1234; instr = 16'h0E05; condFlags = 3'b111;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "nextPc", nextPc, 16'h0000);
    check("R1", "memAddr", memAddr, 16'h0000);
    check("R1", "memAccess", {15'd0, memAccess}, 16'h0000);
    check("R1", "branchTaken", {15'd0, branchTaken}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;

    // R5: PC-relative load/store, negative and positive offsets
    drive(16'h4019, {4'b0010, 3'd2, 9'h1AF}, 16'h0, 3'b000, 16'h0, 1'b0, "R5_ld_neg");
    drive(16'h3000, {4'b0011, 3'd5, 9'h0A0}, 16'h0, 3'b010, 16'h0, 1'b0, "R5_st_pos");
    // R9: phase bit on a plain load has no effect
    drive(16'h3000, {4'b0010, 3'd1, 9'h004}, 16'h0, 3'b000, 16'hBEEF, 1'b1, "R9_ld_ind_ignored");
    // R10: wrap across the top and bottom of the address space
    drive(16'hFFF0, {4'b0010, 3'd0, 9'h0FF}, 16'h0, 3'b000, 16'h0, 1'b0, "R10_pc_wrap_up");
    drive(16'h0004, {4'b1110, 3'd0, 9'h1F0}, 16'h0, 3'b000, 16'h0, 1'b0, "R10_pc_wrap_down");
    // R6: base+offset
    drive(16'h5000, {4'b0110, 3'd3, 3'd4, 6'h3E}, 16'h0006, 3'b001, 16'h0, 1'b0, "R6_ldr_neg");
    drive(16'h5000, {4'b0111, 3'd3, 3'd4, 6'h1F}, 16'h2000, 3'b001, 16'h0, 1'b0, "R6_str_pos");
    drive(16'h5000, {4'b0110, 3'd3, 3'd4, 6'h05}, 16'hFFFE, 3'b001, 16'h0, 1'b0, "R10_base_wrap");
    // R7: address load without access
    drive(16'h3001, {4'b1110, 3'd6, 9'h010}, 16'h0, 3'b100, 16'h0, 1'b0, "R7_lea");
    // R8: both indirect phases, load and store
    drive(16'h3100, {4'b1010, 3'd1, 9'h020}, 16'h0, 3'b000, 16'h7777, 1'b0, "R8_ldi_phase1");
    drive(16'h3100, {4'b1010, 3'd1, 9'h020}, 16'h0, 3'b000, 16'h7777, 1'b1, "R8_ldi_phase2");
    drive(16'h3100, {4'b1011, 3'd1, 9'h1FF}, 16'h0, 3'b000, 16'h8001, 1'b1, "R8_sti_phase2");
    // R2/R3/R4: branch masks against flags
    drive(16'h3050, {4'b0000, 3'b100, 9'h1F8}, 16'h0, 3'b100, 16'h0, 1'b0, "R3_br_n_taken");
    drive(16'h3050, {4'b0000, 3'b010, 9'h010}, 16'h0, 3'b100, 16'h0, 1'b0, "R4_br_z_miss");
    drive(16'h3050, {4'b0000, 3'b001, 9'h0FF}, 16'h0, 3'b001, 16'h0, 1'b0, "R2_br_c_hit");
    drive(16'h3050, {4'b0000, 3'b110, 9'h100}, 16'h0, 3'b010, 16'h0, 1'b0, "R2_br_nz_hit");
    drive(16'h3050, {4'b0000, 3'b000, 9'h010}, 16'h0, 3'b111, 16'h0, 1'b0, "R2_br_mask_zero");
    drive(16'h3050, {4'b0000, 3'b011, 9'h010}, 16'h0, 3'b100, 16'h0, 1'b0, "R4_br_zc_miss");
    // R11: full mask is unconditional
    drive(16'h3050, {4'b0000, 3'b111, 9'h033}, 16'h0, 3'b000, 16'h0, 1'b0, "R11_br_always");
    drive(16'hFFFE, {4'b0000, 3'b111, 9'h005}, 16'h0, 3'b000, 16'h0, 1'b0, "R10_br_wrap");
    // R9: other opcodes, phase bit set
    drive(16'h3200, {4'b0001, 3'd1, 9'h1FF}, 16'h1234, 3'b111, 16'hAAAA, 1'b1, "R9_op_add");
    drive(16'h3200, {4'b1100, 3'd0, 9'h0C0}, 16'h1234, 3'b111, 16'hAAAA, 1'b0, "R9_op_jmp");
    drive(16'h3200, {4'b1111, 3'd0, 9'h025}, 16'h0, 3'b010, 16'hAAAA, 1'b1, "R9_op_trap");
    drive(16'h3300, {4'b0110, 3'd0, 3'd1, 6'h01}, 16'h0100, 3'b000, 16'hCCCC, 1'b1, "R9_ldr_ind_ignored");
    // R4: non-branch with matching-looking mask bits
    drive(16'h3400, {4'b0010, 3'b111, 9'h001}, 16'h0, 3'b111, 16'h0, 1'b0, "R4_ld_no_branch");

    @(negedge clk);
    instr = 16'h1000;
    repeat (3) @(posedge clk);
    #2;
    finishRun();
  end

endmodule